// File: doc/BRIEF.md
# Multi-Source IPC Mailbox Bank

This block is a bank of hardware mailboxes. Up to four processor sources use them to hand short commands to a power-management controller and to get a completion notice back. A source takes a free mailbox by writing its one-hot source ID into the mailbox's owner register. It then reads the owner register back to confirm that it won. Next it fills the data words, picks which sources are masked, and writes its ID to the send register. The remote side answers by pulsing a responder input. In auto-acknowledge mode, a fixed delay stands in for that answer. When the answer arrives, the owner's pending bit is set, and any unmasked pending bit drives that source's interrupt line.

All register access goes through a simple 32-bit bus. Writes take effect on a single-cycle strobe, and reads are combinational from the address. A keyed lock register blocks every register update until the key has been written. Mailbox `m` takes the 64-byte window that starts at address `m*0x40`. The lock register is at `0xA00`.

Top module: `ipc_mbox_bank`

## Requirements
- R1: After reset, every mailbox's status register (offset 0x10) reads 0x10, its owner register (offset 0x00) reads 0, and all interrupt outputs are low.
- R2: A write to any address other than 0xA00 has no effect until 0x1ACCE551 has been written to 0xA00. Writing any other value to 0xA00 locks the bank again.
- R3: When a one-hot ID (bit0 to bit3 each name a source, all other bits zero) is written to the owner register of an idle mailbox, that mailbox becomes owned by the ID. The owner register then reads the ID and the status register reads 0x20.
- R4: While a mailbox is not idle, a write of any other ID to its owner register is ignored.
- R5: Bit 0 of a status-register write selects auto-acknowledge and reads back as bit 0 of the status register. The write is accepted only while the mailbox is owned and not yet sent.
- R6: Writing the owner's ID to the send register (offset 0x1C) of an owned mailbox moves it to the sent state, where the status reads 0x40 | auto. A send written with any other ID is ignored.
- R7: In auto-acknowledge mode, the status register reads 0x80 | 1 exactly ACK_DLY clock edges after the send write.
- R8: In manual mode, the mailbox stays in the sent state until `resp_ack[m]` is high at a clock edge. After that edge it reads 0x80.
- R9: Entering the acknowledged state sets the owner's pending bit. `irq[s]` is high when any mailbox holds pending bit `s` and bit `s` of its mask register (offset 0x14, bits 5:0, 1 = masked) is 0.
- R10: Writing a value to the interrupt-clear register (offset 0x18) clears the pending bits named by bits 3:0 of that value. Pending bits that are not named stay set.
- R11: Writing the owner's ID to the owner register of an owned or acknowledged mailbox releases it. The status returns to 0x10, the owner to 0, auto mode to off, and the pending bits to 0.
- R12: The data words at offset 0x20 + 4*d (d < NDATA) can be written while the mailbox is owned, and they read back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| resp_ack | input | NMBX | Per-mailbox responder acknowledge pulse |
| irq | output | NSRC | Per-source acknowledge interrupt |

## Verification
The assertions assume the following about the inputs: `resp_ack` is driven synchronously, every write is a single-cycle strobe, and the address and data are stable around the clock edge. The stimulus meets this by changing every input just after the falling edge and raising `resp_ack` for exactly one edge, and only while the targeted mailbox is in the sent state. The bench sweeps every source against every mailbox. Each source also contends against each other source, and the bench alternates between auto and manual acknowledge. This keeps every transition inside the legal claim, send, acknowledge and release order, except for the deliberately rejected writes.

// File: rtl/ipc_mbox_bank.sv
module ipc_mbox_bank #(
  parameter int NMBX    = 2,
  parameter int NDATA   = 2,
  parameter int NSRC    = 4,
  parameter int ACK_DLY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NMBX-1:0]  resp_ack,
  output logic [NSRC-1:0]  irq
);
  localparam int          CW        = $clog2(ACK_DLY + 1);
  localparam logic [31:0] KEY       = 32'h1ACC_E551;
  localparam logic [11:0] LOCK_ADDR = 12'hA00;
  localparam logic [5:0]  OFF_SRC   = 6'h00;
  localparam logic [5:0]  OFF_MODE  = 6'h10;
  localparam logic [5:0]  OFF_MASK  = 6'h14;
  localparam logic [5:0]  OFF_ICLR  = 6'h18;
  localparam logic [5:0]  OFF_SEND  = 6'h1C;

  typedef enum logic [1:0] {ST_IDLE, ST_OWN, ST_SENT, ST_ACK} st_t;

  logic                       unlk;
  st_t                        st     [NMBX];
  logic [NMBX-1:0][NSRC-1:0]  owner, pend;
  logic [NMBX-1:0][5:0]       mask;
  logic [NMBX-1:0]            auto_m;
  logic [NMBX-1:0][CW-1:0]    cnt;
  logic [31:0]                data   [NMBX][NDATA];
  logic [NMBX-1:0]            hit;

  wire [5:0]      sel   = bus_addr[11:6];
  wire [5:0]      off   = bus_addr[5:0];
  wire [NSRC-1:0] wid   = bus_wdata[NSRC-1:0];
  wire            id_ok = $onehot(wid) && (bus_wdata[31:NSRC] == '0);

  always_comb
    for (int m = 0; m < NMBX; m++)
      hit[m] = bus_wr && unlk && bus_addr != LOCK_ADDR && sel == 6'(m);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      unlk   <= 1'b0;
      owner  <= '0;
      pend   <= '0;
      mask   <= '0;
      auto_m <= '0;
      cnt    <= '0;
      for (int m = 0; m < NMBX; m++) begin
        st[m] <= ST_IDLE;
        for (int d = 0; d < NDATA; d++) data[m][d] <= '0;
      end
    end else begin
      if (bus_wr && bus_addr == LOCK_ADDR) unlk <= (bus_wdata == KEY);
      for (int m = 0; m < NMBX; m++) begin
        if (hit[m] && off == OFF_MASK && st[m] != ST_IDLE) mask[m] <= bus_wdata[5:0];
        if (hit[m] && off == OFF_ICLR) pend[m] <= pend[m] & ~wid;
        for (int d = 0; d < NDATA; d++)
          if (hit[m] && st[m] == ST_OWN && off == 6'(32 + 4*d)) data[m][d] <= bus_wdata;
        case (st[m])
          ST_IDLE:
            if (hit[m] && off == OFF_SRC && id_ok) begin
              owner[m] <= wid;
              st[m]    <= ST_OWN;
            end
          ST_OWN:
            if (hit[m] && off == OFF_SRC && id_ok && wid == owner[m]) begin
              owner[m] <= '0; pend[m] <= '0; auto_m[m] <= 1'b0; st[m] <= ST_IDLE;
            end else if (hit[m] && off == OFF_MODE) begin
              auto_m[m] <= bus_wdata[0];
            end else if (hit[m] && off == OFF_SEND && id_ok && wid == owner[m]) begin
              st[m]  <= ST_SENT;
              cnt[m] <= CW'(ACK_DLY - 1);
            end
          ST_SENT:
            if ((auto_m[m] && cnt[m] == '0) || (!auto_m[m] && resp_ack[m])) begin
              st[m]   <= ST_ACK;
              pend[m] <= pend[m] | owner[m];
            end else if (auto_m[m]) begin
              cnt[m] <= cnt[m] - 1'b1;
            end
          default:
            if (hit[m] && off == OFF_SRC && id_ok && wid == owner[m]) begin
              owner[m] <= '0; pend[m] <= '0; auto_m[m] <= 1'b0; st[m] <= ST_IDLE;
            end
        endcase
      end
    end

  always_comb begin
    bus_rdata = '0;
    for (int m = 0; m < NMBX; m++)
      if (sel == 6'(m) && bus_addr != LOCK_ADDR) begin
        case (off)
          OFF_SRC:  bus_rdata = 32'(owner[m]);
          OFF_MODE: bus_rdata = {24'b0, 4'(1 << st[m]), 3'b0, auto_m[m]};
          OFF_MASK: bus_rdata = 32'(mask[m]);
          default:  ;
        endcase
        for (int d = 0; d < NDATA; d++)
          if (off == 6'(32 + 4*d)) bus_rdata = data[m][d];
      end
  end

  always_comb begin
    irq = '0;
    for (int m = 0; m < NMBX; m++) irq = irq | (pend[m] & ~mask[m][NSRC-1:0]);
  end

  for (genvar m = 0; m < NMBX; m++) begin : g_chk
    AST_ONE_OWNER:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(owner[m])); // R3
    AST_IDLE_FREE:   assert property (@(posedge clk) disable iff (!rst_n) st[m] == ST_IDLE |-> owner[m] == '0 && pend[m] == '0); // R11
    AST_LOCK_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !unlk |=> $stable(owner[m]) && $stable(mask[m])); // R2
    AST_AUTO_ACK:    assert property (@(posedge clk) disable iff (!rst_n) st[m] == ST_SENT && auto_m[m] && cnt[m] == '0 |=> st[m] == ST_ACK); // R7
    AST_MANUAL_WAIT: assert property (@(posedge clk) disable iff (!rst_n) st[m] == ST_SENT && !auto_m[m] && !resp_ack[m] |=> st[m] == ST_SENT); // R8
    AST_SEND_OWNED:  assert property (@(posedge clk) disable iff (!rst_n) st[m] == ST_SENT |-> $past(st[m]) == ST_OWN || $past(st[m]) == ST_SENT); // R6
  end
endmodule

// File: tb/ipc_mbox_bank_bench.sv
module ipc_mbox_bank_bench;
  localparam int NMBX = 2, NDATA = 2, NSRC = 4, ACK_DLY = 3;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NMBX-1:0] resp_ack = '0;
  logic [NSRC-1:0] irq;
  int checks = 0, fails = 0;
  bit done = 0;

  ipc_mbox_bank #(.NMBX(NMBX), .NDATA(NDATA), .NSRC(NSRC), .ACK_DLY(ACK_DLY)) u_ipc_mbox_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .resp_ack(resp_ack), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int m = 0; m < NMBX; m++) begin
      rd(12'(m*64 + 'h10), v); chk("R1 idle status", v, 32'h10);
      rd(12'(m*64), v);        chk("R1 owner", v, 0);
    end
    chk("R1 irq", 32'(irq), 0);
    wr(12'h000, 1);
    rd(12'h000, v); chk("R2 locked claim", v, 0);
    wr(12'hA00, 32'h1ACCE551);
    wr(12'h050, 1);
    rd(12'h050, v); chk("R5 mode ignored idle", v, 32'h10);

    for (int m = 0; m < NMBX; m++)
      for (int s = 0; s < NSRC; s++) begin
        logic [11:0] b;
        logic [31:0] id, au, other, expirq;
        b = 12'(m*64); id = 32'(1 << s); other = 32'(1 << ((s+1) % NSRC));
        au = ((m + s) % 2 == 0) ? 1 : 0;
        wr(b, id);
        rd(b, v);           chk("R3 claim readback", v, id);
        rd(b + 12'h10, v);  chk("R3 owned status", v, 32'h20);
        for (int c = 0; c < NSRC; c++)
          if (c != s) begin
            wr(b, 32'(1 << c));
            rd(b, v); chk("R4 contender ignored", v, id);
          end
        if (au == 1) wr(b + 12'h10, 1);
        rd(b + 12'h10, v); chk("R5 auto bit", v, 32'h20 | au);
        wr(b + 12'h14, (s == 3) ? 32'h3F : (~id & 32'h3F));
        for (int d = 0; d < NDATA; d++) begin
          wr(b + 12'(32 + 4*d), 32'hA000_0000 + 32'(m*256 + s*16 + d));
          rd(b + 12'(32 + 4*d), v); chk("R12 data", v, 32'hA000_0000 + 32'(m*256 + s*16 + d));
        end
        wr(b + 12'h1C, other);
        rd(b + 12'h10, v); chk("R6 foreign send ignored", v, 32'h20 | au);
        wr(b + 12'h1C, id);
        if (au == 1) begin
          for (int i = 0; i < ACK_DLY; i++) begin
            rd(b + 12'h10, v); chk("R7 still sent", v, 32'h41);
            @(negedge clk);
          end
          rd(b + 12'h10, v); chk("R7 acked on time", v, 32'h81);
        end else begin
          repeat (4) @(negedge clk);
          rd(b + 12'h10, v); chk("R8 waits for responder", v, 32'h40);
          resp_ack[m] = 1; @(posedge clk); @(negedge clk); resp_ack[m] = 0;
          rd(b + 12'h10, v); chk("R8 acked", v, 32'h80);
        end
        expirq = (s == 3) ? 0 : id;
        chk("R9 irq", 32'(irq), expirq);
        if (s == 3) begin
          wr(b + 12'h14, 32'h37);
          chk("R9 unmasked irq", 32'(irq), id);
        end
        wr(b + 12'h18, other);
        chk("R10 other clear keeps irq", 32'(irq), id);
        wr(b + 12'h18, id);
        chk("R10 clear", 32'(irq), 0);
        wr(b, id);
        rd(b + 12'h10, v); chk("R11 released status", v, 32'h10);
        rd(b, v);          chk("R11 released owner", v, 0);
      end

    wr(12'hA00, 0);
    wr(12'h040, 2);
    rd(12'h040, v); chk("R2 relocked", v, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule